// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block gives a host processor twenty-four general-purpose digital lines arranged as three 8-bit ports: A, B and C. Port C is handled as two 4-bit halves. The host reaches the block through a small synchronous register interface. That interface has an 8-bit write bus, an 8-bit read bus, a 2-bit register select and active-low chip-select, read and write strobes. Strobes are sampled on the rising clock edge.

Each pin line has three signals: an input value from the pad, an output value toward the pad and an output-enable. A single write-only control word sets the direction of port A, port B and each half of port C. It also records the operating mode that software asks for on each of the two groups. Group A is port A with the upper half of C. Group B is port B with the lower half of C.

Only basic latched input/output is implemented. A request for a handshake mode is recorded and flagged through a sticky status output, and the ports keep working as basic I/O. A read of port A returns a value captured at the start of the read cycle. A read of port B or of an input half of port C returns the live pin values.

Top module: `ppio_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets as follows: every output-enable goes to 0 (all lines are inputs), every output latch goes to 0x00, `mode_err` goes to 0 and both group modes go to basic (0).
- R2: A control write (`addr`=3) with bit 7 set loads the directions. Bit 4 sets port A, bit 3 sets the upper half of C (pins 7:4), bit 1 sets port B and bit 0 sets the lower half of C (pins 3:0). A value of 1 makes that port or half an input, so its output-enables are 0. A value of 0 makes it an output, so its output-enables are all 1.
- R3: A control write with bit 7 clear changes nothing: directions, modes, status and latches all keep their values.
- R4: A valid control write records the group A mode from bits 6:5 on `mode_a`. 00 gives 0, 01 gives 1, and both 10 and 11 give 2. Bit 2 is recorded on `mode_b`.
- R5: A valid control write that requests a nonzero mode for either group sets `mode_err`. It stays set until reset, and the ports keep working as basic I/O.
- R6: Every valid control write clears the output latches of ports A, B and C to 0x00.
- R7: A write to `addr` 0, 1 or 2 (ports A, B, C) loads that port's output latch, which appears on the port's output value after the clock edge. The latch is written even when the port is an input, and in that case the output-enables stay 0.
- R8: A read of a port or half-port set to output returns its output latch.
- R9: The port A input latch samples `pa_in` at the first clock edge on which a read of `addr` 0 is seen after `rd_n` was high. A read of port A set as input returns that sample, and the sample holds while the strobe stays low.
- R10: A read of port B set as input, or of an input half of port C, returns the live pin values. Each half of port C chooses between live pins and latch on its own.
- R11: A read of the control address (`addr`=3) returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when no read is active |
| pa_in | input | 8 | Port A pin input values |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A output-enables |
| pb_in | input | 8 | Port B pin input values |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B output-enables |
| pc_in | input | 8 | Port C pin input values |
| pc_out | output | 8 | Port C pin output values |
| pc_oe | output | 8 | Port C output-enables, per half |
| mode_a | output | 2 | Recorded group A mode request |
| mode_b | output | 1 | Recorded group B mode request |
| mode_err | output | 1 | Sticky flag: a handshake mode was requested |

## Verification
Writes take effect at the one rising edge inside the one-cycle write strobe. Output values, enables, mode outputs and status therefore all read back at the falling edge that ends the strobe, and the bench checks them there.

Read data is combinational, with one exception: port A in input mode shows the value captured at the first strobed edge. The scoreboard monitor compares each queued read a quarter period after every rising edge on which the strobe is active. At that point the capture has already happened and the inputs are not yet changing.

The held-strobe case queues two items for one port A read. The pins change between them, and both items must return the first sample.

// File: rtl/ppio_pkg.sv
// Package ppio_pkg
// Shared encodings for the parallel I/O controller: register selects,
// group mode codes, control word bit positions and the direction record.
package ppio_pkg;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } ppio_addr_e;

    typedef enum logic [1:0] {
        MODE_BASIC   = 2'd0,
        MODE_STROBED = 2'd1,
        MODE_BIDIR   = 2'd2
    } ppio_mode_e;

    // Control word bit positions (the host software relies on these).
    localparam int CW_FLAG   = 7;
    localparam int CW_AMODE1 = 6;
    localparam int CW_AMODE0 = 5;
    localparam int CW_A_DIR  = 4;
    localparam int CW_CU_DIR = 3;
    localparam int CW_BMODE  = 2;
    localparam int CW_B_DIR  = 1;
    localparam int CW_CL_DIR = 0;

    // Direction record: 1 = input, 0 = output.
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } ppio_dir_t;

endpackage

// File: rtl/ppio_latch.sv
// Module ppio_latch
// One output data latch of parameterised width. Assumes clr and we are
// never requested for the same latch in one cycle; clr wins if they are.
module ppio_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold the last written value; reset or mode-set clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (we)       q <= d;
    end

endmodule

// File: rtl/ppio_ctrl.sv
// Module ppio_ctrl
// Control word register. Accepts a write only when the flag bit is set,
// records directions and requested group modes, and raises a sticky
// error when a handshake mode is requested. Assumes an 8-bit control word.
module ppio_ctrl
    import ppio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] wdata,
    output logic       mode_set,
    output ppio_dir_t  dir,
    output ppio_mode_e mode_a,
    output ppio_mode_e mode_b,
    output logic       mode_err
);

    ppio_mode_e a_req;
    ppio_mode_e b_req;

    // A write is a mode-set only when the flag bit is high.
    assign mode_set = ctl_wr && wdata[CW_FLAG];

    // Decode group mode requests; 10 and 11 both mean bidirectional.
    always_comb begin
        if (wdata[CW_AMODE1])      a_req = MODE_BIDIR;
        else if (wdata[CW_AMODE0]) a_req = MODE_STROBED;
        else                       a_req = MODE_BASIC;
        b_req = wdata[CW_BMODE] ? MODE_STROBED : MODE_BASIC;
    end

    // Register directions, modes and the sticky unsupported-mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir      <= '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
            mode_a   <= MODE_BASIC;
            mode_b   <= MODE_BASIC;
            mode_err <= 1'b0;
        end else if (mode_set) begin
            dir.a_in  <= wdata[CW_A_DIR];
            dir.cu_in <= wdata[CW_CU_DIR];
            dir.b_in  <= wdata[CW_B_DIR];
            dir.cl_in <= wdata[CW_CL_DIR];
            mode_a    <= a_req;
            mode_b    <= b_req;
            if (a_req != MODE_BASIC || b_req != MODE_BASIC) mode_err <= 1'b1;
        end
    end

endmodule

// File: rtl/ppio_rdmux.sv
// Module ppio_rdmux
// Read data selection. Output ports return their latch; input ports return
// the captured (A) or live (B, C halves) pin values. Control reads 0.
// Returns 0 when no read is active.
module ppio_rdmux
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  ppio_addr_e    sel,
    input  logic          rd_act,
    input  ppio_dir_t     dir,
    input  logic [DW-1:0] a_lat,
    input  logic [DW-1:0] a_cap,
    input  logic [DW-1:0] b_lat,
    input  logic [DW-1:0] b_pin,
    input  logic [DW-1:0] c_lat,
    input  logic [DW-1:0] c_pin,
    output logic [DW-1:0] rdata
);

    localparam int HW = DW / 2;

    logic [DW-1:0] c_val;

    // Port C halves pick live pins or latch independently.
    always_comb begin
        c_val[HW-1:0]  = dir.cl_in ? c_pin[HW-1:0]  : c_lat[HW-1:0];
        c_val[DW-1:HW] = dir.cu_in ? c_pin[DW-1:HW] : c_lat[DW-1:HW];
    end

    // Select the addressed port value during an active read.
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (sel)
                SEL_A:   rdata = dir.a_in ? a_cap : a_lat;
                SEL_B:   rdata = dir.b_in ? b_pin : b_lat;
                SEL_C:   rdata = c_val;
                SEL_CTL: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ppio_top.sv
// Module ppio_top
// Three-port parallel I/O controller, basic mode only. Decodes the host
// strobes, owns the output latches and the port A input latch, and drives
// the pin-side enables from the control register. Assumes DW = 8 because
// the control word layout is fixed at eight bits.
module ppio_top
    import ppio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe,
    output logic [1:0]    mode_a,
    output logic          mode_b,
    output logic          mode_err
);

    localparam int HW = DW / 2;

    ppio_addr_e    sel;
    logic          wr_act, rd_act, rd_q, rd_start;
    logic          we_a, we_b, we_c, mode_set;
    ppio_dir_t     dir;
    ppio_mode_e    mode_a_e, mode_b_e;
    logic [DW-1:0] a_lat, b_lat, c_lat, a_cap;
    logic [1:0]    nib_in;

    // Strobe decode.
    assign sel    = ppio_addr_e'(addr);
    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;
    assign we_a   = wr_act && sel == SEL_A;
    assign we_b   = wr_act && sel == SEL_B;
    assign we_c   = wr_act && sel == SEL_C;

    // Remember the previous read strobe level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_n;
    end

    assign rd_start = rd_act && rd_q && sel == SEL_A;

    // Port A input latch: sample the pins at the start of a port A read.
    always_ff @(posedge clk) begin
        if (!rst_n)        a_cap <= '0;
        else if (rd_start) a_cap <= pa_in;
    end

    ppio_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_act && sel == SEL_CTL),
        .wdata    (wdata[7:0]),
        .mode_set (mode_set),
        .dir      (dir),
        .mode_a   (mode_a_e),
        .mode_b   (mode_b_e),
        .mode_err (mode_err)
    );

    ppio_latch #(.W(DW)) u_lat_a (
        .clk(clk), .rst_n(rst_n), .clr(mode_set), .we(we_a), .d(wdata), .q(a_lat)
    );

    ppio_latch #(.W(DW)) u_lat_b (
        .clk(clk), .rst_n(rst_n), .clr(mode_set), .we(we_b), .d(wdata), .q(b_lat)
    );

    // Port C: one latch and one enable group per half.
    assign nib_in = {dir.cu_in, dir.cl_in};

    for (genvar n = 0; n < 2; n++) begin : g_cnib
        ppio_latch #(.W(HW)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (mode_set),
            .we    (we_c),
            .d     (wdata[n*HW +: HW]),
            .q     (c_lat[n*HW +: HW])
        );
        assign pc_oe[n*HW +: HW] = {HW{~nib_in[n]}};
    end

    // Pin-side outputs.
    assign pa_out = a_lat;
    assign pb_out = b_lat;
    assign pc_out = c_lat;
    assign pa_oe  = {DW{~dir.a_in}};
    assign pb_oe  = {DW{~dir.b_in}};
    assign mode_a = mode_a_e;
    assign mode_b = (mode_b_e == MODE_STROBED);

    ppio_rdmux #(.DW(DW)) u_rdmux (
        .sel    (sel),
        .rd_act (rd_act),
        .dir    (dir),
        .a_lat  (a_lat),
        .a_cap  (a_cap),
        .b_lat  (b_lat),
        .b_pin  (pb_in),
        .c_lat  (c_lat),
        .c_pin  (pc_in),
        .rdata  (rdata)
    );

endmodule

// File: rtl/ppio_chk.sv
// Module ppio_chk
// Property checker for ppio_top, attached by bind. Observes ports only.
module ppio_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] pa_out,
    input logic [DW-1:0] pa_oe,
    input logic [DW-1:0] pb_out,
    input logic [DW-1:0] pb_oe,
    input logic [DW-1:0] pc_out,
    input logic [DW-1:0] pc_oe,
    input logic [1:0]    mode_a,
    input logic          mode_err
);

    localparam int HW = DW / 2;

    logic ctl_wr;
    assign ctl_wr = !cs_n && !wr_n && addr == 2'd3;

    // R1: reset leaves every line an input and the error clear.
    a_r1_reset_inputs: assert property (@(posedge clk)
        !rst_n |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && !mode_err));

    // R2: enables are uniform across each port and each half of C.
    a_r2_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1) &&
        (pc_oe[HW-1:0] == '0 || pc_oe[HW-1:0] == '1) &&
        (pc_oe[DW-1:HW] == '0 || pc_oe[DW-1:HW] == '1));

    // R3: a control write without the flag changes nothing.
    a_r3_flagless_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) &&
        $stable(pc_oe) && $stable(mode_a) && $stable(mode_err) &&
        $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

    // R5: a handshake request raises the error flag.
    a_r5_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7] && (wdata[6] || wdata[5] || wdata[2])) |=> mode_err);

    // R5: the error flag is sticky.
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    // R6: a mode-set write clears every output latch.
    a_r6_clear_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R11: the control address reads as zero.
    a_r11_ctl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr == 2'd3) |-> rdata == '0);

endmodule

bind ppio_top ppio_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pa_out   (pa_out),
    .pa_oe    (pa_oe),
    .pb_out   (pb_out),
    .pb_oe    (pb_oe),
    .pc_out   (pc_out),
    .pc_oe    (pc_oe),
    .mode_a   (mode_a),
    .mode_err (mode_err)
);

// File: tb/ppio_top_test.sv
// Scoreboard bench for ppio_top: read tasks queue expected data, a monitor
// compares rdata a quarter period after each strobed rising edge; pin-side
// results are checked at the falling edge that ends each write.
module ppio_top_test;

    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [1:0] mode_a;
    logic       mode_b, mode_err;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    always #(PER/2) clk = ~clk;

    ppio_top uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .mode_a(mode_a), .mode_b(mode_b), .mode_err(mode_err)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(logic [1:0] a, logic [7:0] e, string req);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        sb.push_back('{e, req});
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare one item per strobed read cycle.
    initial begin
        forever begin
            @(posedge clk);
            #(PER/4);
            if (!cs_n && !rd_n) begin
                if (sb.size() == 0) begin
                    chk("scoreboard empty on read", rdata, 8'hxx);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(it.req, rdata, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(PER * 20000);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 pa_out", pa_out, 8'h00);
        chk("R1 mode_err", {7'd0, mode_err}, 8'h00);
        chk("R1 mode_a", {6'd0, mode_a}, 8'h00);
        bus_rd(2'd3, 8'h00, "R11 control read");

        // R2 all outputs, basic mode
        bus_wr(2'd3, 8'h80);
        chk("R2 pa_oe", pa_oe, 8'hFF);
        chk("R2 pb_oe", pb_oe, 8'hFF);
        chk("R2 pc_oe", pc_oe, 8'hFF);
        chk("R5 no error in basic", {7'd0, mode_err}, 8'h00);
        bus_wr(2'd0, 8'h3C);
        chk("R7 pa_out", pa_out, 8'h3C);
        bus_rd(2'd0, 8'h3C, "R8 read A latch");
        bus_wr(2'd1, 8'hA5);
        bus_wr(2'd2, 8'h96);
        bus_rd(2'd1, 8'hA5, "R8 read B latch");
        bus_rd(2'd2, 8'h96, "R8 read C latch");

        // R3 flagless control write ignored
        bus_wr(2'd3, 8'h05);
        chk("R3 pa_oe", pa_oe, 8'hFF);
        chk("R3 pb_oe", pb_oe, 8'hFF);
        chk("R3 pc_oe", pc_oe, 8'hFF);
        chk("R3 pa_out", pa_out, 8'h3C);
        chk("R3 mode_b", {7'd0, mode_b}, 8'h00);

        // Port C fully input, latches cleared
        bus_wr(2'd3, 8'h89);
        chk("R2 pc_oe input", pc_oe, 8'h00);
        chk("R2 pa_oe kept", pa_oe, 8'hFF);
        chk("R6 pa_out cleared", pa_out, 8'h00);
        chk("R6 pb_out cleared", pb_out, 8'h00);
        chk("R6 pc_out cleared", pc_out, 8'h00);
        pc_in = 8'h7E;
        bus_rd(2'd2, 8'h7E, "R10 C live pins");

        // Upper half input, lower half output
        bus_wr(2'd3, 8'h88);
        chk("R2 pc_oe split", pc_oe, 8'h0F);
        bus_wr(2'd2, 8'hB4);
        chk("R7 pc_out", pc_out, 8'hB4);
        pc_in = 8'h21;
        bus_rd(2'd2, 8'h24, "R10 C halves independent");

        // Port B input
        bus_wr(2'd3, 8'h82);
        chk("R2 pb_oe input", pb_oe, 8'h00);
        chk("R2 pc_oe output", pc_oe, 8'hFF);
        bus_wr(2'd1, 8'h11);
        chk("R7 pb_out on input port", pb_out, 8'h11);
        chk("R7 pb_oe stays off", pb_oe, 8'h00);
        pb_in = 8'h6D;
        bus_rd(2'd1, 8'h6D, "R10 B live pins");

        // Port A input, captured read held across strobe
        bus_wr(2'd3, 8'h90);
        chk("R2 pa_oe input", pa_oe, 8'h00);
        bus_wr(2'd0, 8'h99);
        chk("R7 pa_out on input port", pa_out, 8'h99);
        pa_in = 8'h5A;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 2'd0;
        sb.push_back('{8'h5A, "R9 capture at strobe start"});
        sb.push_back('{8'h5A, "R9 capture held"});
        @(negedge clk);
        pa_in = 8'hC3;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        bus_rd(2'd0, 8'hC3, "R9 new capture");

        // Mode requests
        bus_wr(2'd3, 8'hA0);
        chk("R4 mode_a 01", {6'd0, mode_a}, 8'h01);
        chk("R5 err set", {7'd0, mode_err}, 8'h01);
        chk("R5 pa still basic", pa_oe, 8'hFF);
        bus_wr(2'd3, 8'hC0);
        chk("R4 mode_a 10", {6'd0, mode_a}, 8'h02);
        bus_wr(2'd3, 8'hE0);
        chk("R4 mode_a 11", {6'd0, mode_a}, 8'h02);
        bus_wr(2'd0, 8'h77);
        chk("R5 basic write works", pa_out, 8'h77);
        bus_rd(2'd0, 8'h77, "R5 basic read works");
        bus_wr(2'd3, 8'h84);
        chk("R4 mode_b", {7'd0, mode_b}, 8'h01);
        chk("R4 mode_a back", {6'd0, mode_a}, 8'h00);
        bus_wr(2'd3, 8'h80);
        chk("R5 err sticky", {7'd0, mode_err}, 8'h01);
        chk("R4 mode_b cleared", {7'd0, mode_b}, 8'h00);

        // Reset after configuration
        do_reset();
        @(negedge clk);
        chk("R1 err cleared", {7'd0, mode_err}, 8'h00);
        chk("R1 pa_oe after use", pa_oe, 8'h00);
        chk("R1 pc_oe after use", pc_oe, 8'h00);
        bus_wr(2'd3, 8'h84);
        chk("R5 group B request", {7'd0, mode_err}, 8'h01);

        repeat (2) @(negedge clk);
        chk("scoreboard drained", 8'(sb.size()), 8'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule